// File: doc/BRIEF.md
# I2C Slave Port with Address Match

This block is the target side of a two-wire serial bus. It samples the clock and data pins with the system clock and detects the bus framing conditions. Bytes move in and out most significant bit first. The first byte after a framing start is compared against a programmable 7-bit device address, and the bus-wide broadcast address can also be accepted when enabled. The pads are open-drain: the block never drives a high level. It only requests that the data line be pulled low.

Each completed incoming byte is copied from the hidden shift register into a readable holding buffer, and an interrupt flag is raised. This makes the receive side double-buffered. The transmit side is not double-buffered: a write to the buffer loads the same byte into the buffer and into the shift register at once. Two status bits report the most recent framing condition seen on the bus, so that software can tell whether the bus is free.

The control sequence has nine states. IDLE waits for a start. ADDR shifts in the address byte. RX shifts in a data byte. ACK_OUT waits for the clock to fall after the eighth bit. ACK_HOLD drives the acknowledge during the ninth clock. TX shifts a byte out. TX_ACK samples the master's acknowledge. TX_NEXT either starts the next byte or gives up. WAIT ignores traffic until the next framing condition.

The transitions are as follows:
- A start goes from any state to ADDR.
- A stop goes from any state to IDLE.
- ADDR or RX goes to ACK_OUT on the eighth rising clock.
- ACK_OUT goes to ACK_HOLD on a falling clock.
- ACK_HOLD goes to TX, RX or WAIT on a falling clock.
- TX goes to TX_ACK after eight falling clocks.
- TX_ACK goes to TX_NEXT on a rising clock.
- TX_NEXT goes to TX or WAIT on a falling clock.

Top module: `i2c_slave_port`

## Requirements
- R1: After reset both framing status bits are 0. A start condition (data falls while clock is high) sets `bus_start` and clears `bus_stop`. A stop condition (data rises while clock is high) sets `bus_stop` and clears `bus_start`.
- R2: The byte after a start carries the 7-bit address in bits 7..1 and the direction in bit 0. The line is pulled low during the ninth clock only when those bits equal `own_addr` and the buffer is empty.
- R3: The all-zero address byte 0x00 is acknowledged only while `gc_en` is 1. With `gc_en` at 0 it is treated as a mismatch.
- R4: An acknowledged byte (a matched address or accepted data) appears on `buf_rdata` and sets `buf_full` and `irq`. `buf_rd` clears `buf_full`, and `irq_clr` clears `irq`.
- R5: After a matched address with bit 0 at 0, data bytes are sampled on rising clock edges, MSb first, and are acknowledged while the buffer is empty.
- R6: When a byte that would be accepted completes while `buf_full` is 1, `ovf` is set, the byte is not acknowledged, and `buf_rdata` keeps its old value. `ovf_clr` clears `ovf`.
- R7: After a matched address with bit 0 at 1, the shift register content is sent MSb first. A 0 bit pulls the line low and a 1 bit releases it.
- R8: After a master NACK the line is released, and later bytes are not acknowledged until the next start.
- R9: A start while a transfer is in progress restarts address reception.
- R10: `buf_wr` loads `buf_wdata` into both `buf_rdata` and the transmit shift register.
- R11: `irq` is set on the rising clock of the acknowledge bit of each transmitted byte.
- R12: After a mismatched address, the line is not pulled low for any byte until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Clock pin sample |
| sda_in | input | 1 | Data pin sample |
| sda_oe | output | 1 | 1 pulls the data pin low |
| own_addr | input | 7 | Device address |
| gc_en | input | 1 | Accept the all-zero broadcast address |
| buf_wr | input | 1 | Write strobe for the buffer and the shift register |
| buf_wdata | input | 8 | Write data |
| buf_rd | input | 1 | Read acknowledge; clears buf_full |
| buf_rdata | output | 8 | Holding buffer contents |
| buf_full | output | 1 | Buffer holds an unread byte |
| irq | output | 1 | Byte completion flag |
| irq_clr | input | 1 | Clears irq |
| ovf | output | 1 | Overflow flag |
| ovf_clr | input | 1 | Clears ovf |
| bus_start | output | 1 | Last framing condition was a start |
| bus_stop | output | 1 | Last framing condition was a stop |
| rw_mode | output | 1 | Slave-transmit mode is active |

## Verification
A wrong state or a wrong bit count in the sequencer shows up at the pins within one byte time. The acknowledge then arrives in the wrong clock or is missing, and transmitted bits are displaced by one position. A wrong flag update shows up on `buf_full`, `irq`, `ovf` or the framing bits a few system clocks after the clock edge that caused it. The bench compares those flags against its model on every quiet clock, so such a fault is caught almost at once. The acknowledge and the transmitted data are checked bit by bit at the end of each high clock phase.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_RX,
        ST_ACK_OUT,
        ST_ACK_HOLD,
        ST_TX,
        ST_TX_ACK,
        ST_TX_NEXT,
        ST_WAIT
    } i2cs_state_e;

    localparam logic [7:0] BCAST_ADDR = 8'h00;
endpackage

// File: rtl/i2cs_pin_sync.sv
module i2cs_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_pipe, sda_pipe;
    logic scl_p, sda_p, scl_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_p    <= 1'b1;
            sda_p    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
            scl_p    <= scl_pipe[STAGES-1];
            sda_p    <= sda_pipe[STAGES-1];
        end
    end

    assign scl_s     = scl_pipe[STAGES-1];
    assign sda_s     = sda_pipe[STAGES-1];
    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    assign start_det = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/i2cs_engine.sv
module i2cs_engine
    import i2cs_pkg::*;
#(
    parameter int ADDR_W = 7,
    localparam int DW = ADDR_W + 1,
    localparam int CW = $clog2(DW)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              sda_s,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              gc_en,
    input  logic              room,
    input  logic              tx_load,
    input  logic [DW-1:0]     tx_data,
    output logic              sda_oe,
    output logic              rx_push,
    output logic              rx_drop,
    output logic [DW-1:0]     rx_byte,
    output logic              tx_done,
    output logic              rw_mode
);
    i2cs_state_e st, st_nx;
    logic [CW-1:0] cnt;
    logic [DW-1:0] sh;
    logic ack_q, rw_q, oe_q, nack_q;
    logic last_bit, hit, rx_end, want;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // next state
    always_comb begin
        st_nx = st;
        if (start_det)     st_nx = ST_ADDR;
        else if (stop_det) st_nx = ST_IDLE;
        else begin
            unique case (st)
                ST_IDLE, ST_WAIT: st_nx = st;
                ST_ADDR, ST_RX:   if (rx_end) st_nx = ST_ACK_OUT;
                ST_ACK_OUT:       if (scl_fall) st_nx = ST_ACK_HOLD;
                ST_ACK_HOLD:      if (scl_fall) st_nx = !ack_q ? ST_WAIT : (rw_q ? ST_TX : ST_RX);
                ST_TX:            if (scl_fall && last_bit) st_nx = ST_TX_ACK;
                ST_TX_ACK:        if (scl_rise) st_nx = ST_TX_NEXT;
                ST_TX_NEXT:       if (scl_fall) st_nx = nack_q ? ST_WAIT : ST_TX;
                default:          st_nx = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        last_bit = (cnt == CW'(DW - 1));
        rx_byte  = {sh[DW-2:0], sda_s};
        hit      = (rx_byte[DW-1:1] == own_addr) || (gc_en && rx_byte == BCAST_ADDR);
        rx_end   = scl_rise && last_bit && (st == ST_ADDR || st == ST_RX);
        want     = (st == ST_RX) || hit;
        rx_push  = rx_end && want && room;
        rx_drop  = rx_end && want && !room;
        tx_done  = (st == ST_TX_ACK) && scl_rise;
        sda_oe   = oe_q;
        rw_mode  = rw_q;
    end

    // shift, count and pin drive
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh     <= '0;
            cnt    <= '0;
            ack_q  <= 1'b0;
            rw_q   <= 1'b0;
            oe_q   <= 1'b0;
            nack_q <= 1'b0;
        end else begin
            if (tx_load) sh <= tx_data;
            if (start_det) begin
                cnt   <= '0;
                rw_q  <= 1'b0;
                ack_q <= 1'b0;
                oe_q  <= 1'b0;
            end else if (stop_det) begin
                rw_q <= 1'b0;
                oe_q <= 1'b0;
            end else begin
                case (st)
                    ST_ADDR, ST_RX: if (scl_rise) begin
                        sh <= rx_byte;
                        if (last_bit) begin
                            cnt   <= '0;
                            ack_q <= rx_push;
                            if (st == ST_ADDR) rw_q <= rx_byte[0] && rx_push;
                        end else begin
                            cnt <= cnt + CW'(1);
                        end
                    end
                    ST_ACK_OUT: if (scl_fall) oe_q <= ack_q;
                    ST_ACK_HOLD: if (scl_fall) begin
                        oe_q <= (ack_q && rw_q) ? ~sh[DW-1] : 1'b0;
                        cnt  <= '0;
                    end
                    ST_TX: if (scl_fall) begin
                        if (last_bit) begin
                            oe_q <= 1'b0;
                            cnt  <= '0;
                        end else begin
                            sh   <= {sh[DW-2:0], 1'b0};
                            oe_q <= ~sh[DW-2];
                            cnt  <= cnt + CW'(1);
                        end
                    end
                    ST_TX_ACK: if (scl_rise) nack_q <= sda_s;
                    ST_TX_NEXT: if (scl_fall) begin
                        oe_q <= nack_q ? 1'b0 : ~sh[DW-1];
                        cnt  <= '0;
                    end
                    default: oe_q <= 1'b0;
                endcase
            end
        end
    end

    // R7: transmit only after a read-direction address
    a_r7_tx_needs_rw: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_TX) |-> rw_q);
    // R8 / R12: no drive while idle or ignoring traffic
    a_r8_released_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WAIT || st == ST_IDLE) |-> !sda_oe);
endmodule

// File: rtl/i2cs_regs.sv
module i2cs_regs #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_det,
    input  logic          stop_det,
    input  logic          rx_push,
    input  logic          rx_drop,
    input  logic [DW-1:0] rx_byte,
    input  logic          tx_done,
    input  logic          buf_wr,
    input  logic [DW-1:0] buf_wdata,
    input  logic          buf_rd,
    input  logic          irq_clr,
    input  logic          ovf_clr,
    output logic [DW-1:0] buf_q,
    output logic          full_q,
    output logic          irq_q,
    output logic          ovf_q,
    output logic          s_q,
    output logic          p_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_q  <= '0;
            full_q <= 1'b0;
            irq_q  <= 1'b0;
            ovf_q  <= 1'b0;
            s_q    <= 1'b0;
            p_q    <= 1'b0;
        end else begin
            if (rx_push)     buf_q <= rx_byte;
            else if (buf_wr) buf_q <= buf_wdata;

            if (rx_push)     full_q <= 1'b1;
            else if (buf_rd) full_q <= 1'b0;

            if (rx_push || tx_done) irq_q <= 1'b1;
            else if (irq_clr)       irq_q <= 1'b0;

            if (rx_drop)      ovf_q <= 1'b1;
            else if (ovf_clr) ovf_q <= 1'b0;

            if (start_det) begin
                s_q <= 1'b1;
                p_q <= 1'b0;
            end else if (stop_det) begin
                s_q <= 1'b0;
                p_q <= 1'b1;
            end
        end
    end

    a_r1_start_sets_s: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (s_q && !p_q));
    a_r1_stop_sets_p: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (p_q && !s_q));
    a_r1_sp_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(s_q && p_q));
    a_r4_push_flags: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |=> (full_q && irq_q && buf_q == $past(rx_byte)));
    a_r6_drop_keeps_buf: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_drop && !buf_wr) |=> (ovf_q && $stable(buf_q)));
endmodule

// File: rtl/i2c_slave_port.sv
module i2c_slave_port #(
    parameter int ADDR_W      = 7,
    parameter int SYNC_STAGES = 2,
    localparam int BYTE_W     = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_oe,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              gc_en,
    input  logic              buf_wr,
    input  logic [BYTE_W-1:0] buf_wdata,
    input  logic              buf_rd,
    output logic [BYTE_W-1:0] buf_rdata,
    output logic              buf_full,
    output logic              irq,
    input  logic              irq_clr,
    output logic              ovf,
    input  logic              ovf_clr,
    output logic              bus_start,
    output logic              bus_stop,
    output logic              rw_mode
);
    logic sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic rx_push, rx_drop, tx_done;
    logic [BYTE_W-1:0] rx_byte;

    i2cs_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2cs_engine #(.ADDR_W(ADDR_W)) u_eng (
        .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det), .sda_s(sda_s),
        .own_addr(own_addr), .gc_en(gc_en), .room(~buf_full),
        .tx_load(buf_wr), .tx_data(buf_wdata), .sda_oe(sda_oe),
        .rx_push(rx_push), .rx_drop(rx_drop), .rx_byte(rx_byte),
        .tx_done(tx_done), .rw_mode(rw_mode)
    );

    i2cs_regs #(.DW(BYTE_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .start_det(start_det), .stop_det(stop_det),
        .rx_push(rx_push), .rx_drop(rx_drop), .rx_byte(rx_byte),
        .tx_done(tx_done), .buf_wr(buf_wr), .buf_wdata(buf_wdata),
        .buf_rd(buf_rd), .irq_clr(irq_clr), .ovf_clr(ovf_clr),
        .buf_q(buf_rdata), .full_q(buf_full), .irq_q(irq), .ovf_q(ovf),
        .s_q(bus_start), .p_q(bus_stop)
    );
endmodule

// File: tb/i2c_slave_port_tb_top.sv
module i2c_slave_port_tb_top;
    localparam int P = 8;
    localparam logic [6:0] OWN = 7'h2D;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n = 1'b0;
    logic mscl = 1'b1, msda = 1'b1;
    logic sda_oe, gc = 1'b0;
    logic buf_wr = 1'b0, buf_rd = 1'b0, irq_clr = 1'b0, ovf_clr = 1'b0;
    logic [7:0] buf_wdata = 8'h00, buf_rdata;
    logic buf_full, irq, ovf, bus_start, bus_stop, rw_mode;
    wire sda_line = msda & ~sda_oe;

    i2c_slave_port dut_i (
        .clk(clk), .rst_n(rst_n), .scl_in(mscl), .sda_in(sda_line),
        .sda_oe(sda_oe), .own_addr(OWN), .gc_en(gc), .buf_wr(buf_wr),
        .buf_wdata(buf_wdata), .buf_rd(buf_rd), .buf_rdata(buf_rdata),
        .buf_full(buf_full), .irq(irq), .irq_clr(irq_clr), .ovf(ovf),
        .ovf_clr(ovf_clr), .bus_start(bus_start), .bus_stop(bus_stop),
        .rw_mode(rw_mode)
    );

    int total = 0, bad = 0;
    // behavioural model
    logic exp_s = 0, exp_p = 0, exp_full = 0, exp_irq = 0, exp_ovf = 0;
    logic [7:0] exp_buf = 8'h00;
    int m_phase = 0;   // 0 ignore, 1 address, 2 receive, 3 transmit
    int quiet = 0;
    logic run = 1'b0;
    logic pscl = 1'b1, psda = 1'b1;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // per-clock comparison of the flags once the pins have been quiet
    always @(negedge clk) begin
        if (run) begin
            if (mscl != pscl || msda != psda || buf_rd || buf_wr || irq_clr || ovf_clr) quiet = 0;
            else if (quiet < 1000) quiet++;
            pscl = mscl;
            psda = msda;
            if (quiet >= 5) begin
                if (bus_start != exp_s) chk(0, "R1", "bus_start", bus_start, exp_s); else total++;
                if (bus_stop != exp_p)  chk(0, "R1", "bus_stop", bus_stop, exp_p); else total++;
                if (buf_full != exp_full) chk(0, "R4", "buf_full", buf_full, exp_full); else total++;
                if (irq != exp_irq) chk(0, "R4/R11", "irq", irq, exp_irq); else total++;
                if (ovf != exp_ovf) chk(0, "R6", "ovf", ovf, exp_ovf); else total++;
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic bit hits(input logic [7:0] b);
        return (b[7:1] == OWN) || (gc && b == 8'h00);
    endfunction

    task automatic wr_buf(input logic [7:0] v);
        buf_wr = 1'b1; buf_wdata = v; exp_buf = v;
        tick(1);
        buf_wr = 1'b0;
    endtask

    task automatic rd_buf(input logic [7:0] v, input string req);
        chk(buf_rdata == v, req, "buf_rdata", buf_rdata, v);
        buf_rd = 1'b1; exp_full = 1'b0;
        tick(1);
        buf_rd = 1'b0;
        tick(2);
    endtask

    task automatic clr_irq();
        irq_clr = 1'b1; exp_irq = 1'b0;
        tick(1);
        irq_clr = 1'b0;
        tick(2);
    endtask

    task automatic clr_ovf();
        ovf_clr = 1'b1; exp_ovf = 1'b0;
        tick(1);
        ovf_clr = 1'b0;
        tick(2);
    endtask

    task automatic do_start();
        if (!mscl) begin
            msda = 1'b1; tick(P);
            mscl = 1'b1; tick(P);
        end
        msda = 1'b0; exp_s = 1'b1; exp_p = 1'b0; m_phase = 1;
        tick(P);
        mscl = 1'b0; tick(P);
    endtask

    task automatic do_stop();
        msda = 1'b0; tick(P);
        mscl = 1'b1; tick(P);
        msda = 1'b1; exp_p = 1'b1; exp_s = 1'b0; m_phase = 0;
        tick(P);
    endtask

    // master writes a byte; optional buffer write during the ack clock
    task automatic send_byte(input logic [7:0] b, input bit ld, input logic [7:0] ldv, input string req);
        bit rcv, ack_exp;
        rcv = (m_phase == 1 && hits(b)) || m_phase == 2;
        ack_exp = rcv && !exp_full;
        for (int i = 7; i >= 0; i--) begin
            tick(2); msda = b[i];
            tick(P); mscl = 1'b1;
            if (i == 0 && rcv) begin
                if (exp_full) exp_ovf = 1'b1;
                else begin exp_full = 1'b1; exp_irq = 1'b1; exp_buf = b; end
            end
            tick(P); mscl = 1'b0;
        end
        tick(2); msda = 1'b1;
        tick(P); mscl = 1'b1;
        if (ld) begin tick(3); wr_buf(ldv); tick(P - 4); end
        else tick(P);
        chk(sda_line == !ack_exp, req, "ack (line level)", sda_line, !ack_exp);
        mscl = 1'b0;
        if (m_phase == 1) m_phase = ack_exp ? (b[0] ? 3 : 2) : 0;
        else if (m_phase == 2 && !ack_exp) m_phase = 0;
    endtask

    // master reads a byte; mack=1 acknowledges
    task automatic read_byte(input bit mack, input bit ld, input logic [7:0] ldv,
                             input logic [7:0] expd, input string req);
        logic [7:0] d;
        for (int i = 7; i >= 0; i--) begin
            tick(2); msda = 1'b1;
            tick(P); mscl = 1'b1;
            tick(P); d[i] = sda_line; mscl = 1'b0;
        end
        chk(d == expd, req, "transmitted byte", d, expd);
        tick(2); msda = !mack;
        tick(P); mscl = 1'b1; exp_irq = 1'b1;   // R11
        if (ld) begin tick(3); wr_buf(ldv); tick(P - 4); end
        else tick(P);
        mscl = 1'b0;
        if (!mack) m_phase = 0;
    endtask

    initial begin
        tick(4);
        chk(bus_start == 0 && bus_stop == 0, "R1", "reset framing bits", {bus_start, bus_stop}, 0);
        chk(buf_full == 0 && irq == 0 && ovf == 0, "R4", "reset flags", {buf_full, irq, ovf}, 0);
        chk(sda_oe == 0, "R2", "reset drive", sda_oe, 0);
        rst_n = 1'b1;
        tick(2);
        run = 1'b1;

        // R1, R2, R5: write transfer
        do_start();
        send_byte(8'h5A, 0, 0, "R2");
        rd_buf(8'h5A, "R4");
        clr_irq();
        send_byte(8'hA5, 0, 0, "R5");
        rd_buf(8'hA5, "R5");
        send_byte(8'h3C, 0, 0, "R5");
        rd_buf(8'h3C, "R5");
        clr_irq();
        do_stop();
        tick(P);

        // R12: other address is ignored with its data
        do_start();
        send_byte(8'h40, 0, 0, "R12");
        send_byte(8'h00, 0, 0, "R12");
        chk(buf_full == 0, "R12", "buffer untouched", buf_full, 0);
        do_stop();

        // R3: broadcast address gated by gc_en
        do_start();
        send_byte(8'h00, 0, 0, "R3");
        do_stop();
        gc = 1'b1;
        do_start();
        send_byte(8'h00, 0, 0, "R3");
        rd_buf(8'h00, "R3");
        send_byte(8'h12, 0, 0, "R3");
        rd_buf(8'h12, "R3");
        clr_irq();
        do_stop();
        gc = 1'b0;

        // R6: overflow
        do_start();
        send_byte(8'h5A, 0, 0, "R2");
        send_byte(8'h77, 0, 0, "R6");
        chk(buf_rdata == 8'h5A, "R6", "buffer kept", buf_rdata, 8'h5A);
        rd_buf(8'h5A, "R6");
        clr_ovf();
        clr_irq();
        do_stop();

        // R7, R8, R10, R11: read transfer
        do_start();
        send_byte(8'h5B, 1, 8'hC3, "R7");
        chk(rw_mode == 1, "R7", "rw_mode", rw_mode, 1);
        rd_buf(8'hC3, "R10");
        clr_irq();
        read_byte(1, 1, 8'h81, 8'hC3, "R7");
        clr_irq();
        read_byte(0, 0, 8'h00, 8'h81, "R8");
        tick(4);
        chk(sda_oe == 0, "R8", "released after NACK", sda_oe, 0);
        send_byte(8'h00, 0, 0, "R8");
        clr_irq();
        do_stop();

        // R9: repeated start
        do_start();
        send_byte(8'h5A, 0, 0, "R9");
        rd_buf(8'h5A, "R9");
        send_byte(8'h10, 0, 0, "R9");
        rd_buf(8'h10, "R9");
        do_start();
        send_byte(8'h5A, 0, 0, "R9");
        rd_buf(8'h5A, "R9");
        clr_irq();
        do_stop();
        tick(P);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule